// File: doc/BRIEF.md
# Calibration DAC Serial Loader

This block sets a bank of 8-bit trim DACs over a shared two-wire serial path: a bit clock, a data line, and a separate load strobe that latches the shifted word into the addressed DAC. A host presents a channel number and a value with a one-cycle request. The block sends a 12-bit frame made of the channel field and then the value, and afterwards pulses the load strobe. A per-channel cache holds the last value sent to each DAC. A request whose value already matches the cache produces no traffic on the wires and completes at once.

When reset is released, the block walks every channel in ascending order and programs each one to mid-scale. It stays busy until this sweep has finished. A separate channel-addressed read port returns the cached values. Two select lines for a serial memory that shares the same clock and data wires are held low throughout, so the memory never sees this traffic.

Top module: `caldac_loader`

## Requirements
- R1: While reset is held, and after it is released until the last sweep frame has been latched, `busy` is 1 and `done` stays 0. The sweep sends exactly one frame per channel, channels 0 to NUM_CH-1 in ascending order, each with value 127. `busy` then falls without a `done` pulse.
- R2: A frame is 12 bits: a 4-bit channel followed by an 8-bit value, each most significant bit first. Each bit is placed on `dac_sdata` while `dac_sclk` is low and is taken on the rising edge of `dac_sclk`.
- R3: After the 12th rising edge, `dac_load` goes high for HALF cycles and then returns low. `dac_load` is never high while `dac_sclk` is high, and it is low for the whole shift.
- R4: `eep_sel` and `eep_wr_rel` are 0 in every cycle.
- R5: An accepted request whose value differs from the cached value for its channel sends one frame carrying that channel and value and updates the cache. `busy` is 1 in the cycle after acceptance. The transfer ends with a one-cycle `done` pulse, after the load pulse, in the cycle where `busy` returns to 0.
- R6: An accepted request whose value equals the cached value sends no frame. `done` is 1 in the next cycle, `busy` stays 0, and such requests may be issued back to back, one per cycle.
- R7: A request is ignored, with no frame, no cache change and no `done`, when `busy` is 1 in its cycle or when its channel is NUM_CH or higher.
- R8: `rd_value` shows, one cycle after `rd_chan` is presented, the cache entry for that channel as it was before that clock edge. A read in the same cycle as an accepted write returns the old value, and the new value appears one cycle later. A channel at or beyond NUM_CH reads as 0.
- R9: `dac_sclk` is low when idle. Each bit spends HALF cycles with the clock low and HALF with it high, and `dac_sdata` does not change while `dac_sclk` is high.
- R10: `done` is never 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_chan | input | CH_W | Requested DAC channel |
| req_value | input | VAL_W | Requested trim value |
| busy | output | 1 | Sweep or transfer in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse for a request |
| rd_chan | input | CH_W | Cache read address |
| rd_value | output | VAL_W | Cached value, one cycle after address |
| dac_sclk | output | 1 | Serial bit clock |
| dac_sdata | output | 1 | Serial data |
| dac_load | output | 1 | DAC latch strobe |
| eep_sel | output | 1 | Shared-bus memory select, held low |
| eep_wr_rel | output | 1 | Shared-bus memory write release, held low |

## Verification
Cache readback and cache update can fall in the same cycle. The bench provokes this by leaving `rd_chan` on a channel and then writing a new value to that same channel, so the read and the acceptance coincide. Each cycle, the model predicts `rd_value` from its cache as it stood before the edge and applies the update afterwards, which requires the old value first and the new value one cycle later. A run of back-to-back matching requests also puts a skip completion in every cycle, and each `done` is checked against the model's skip decision for that cycle.

// File: rtl/caldac_pkg.sv
package caldac_pkg;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_LO,
      SH_HI,
      SH_LD
   } sh_state_t;

   typedef enum logic [1:0] {
      LD_INIT_GO,
      LD_INIT_WAIT,
      LD_IDLE,
      LD_XFER
   } ld_state_t;

endpackage

// File: rtl/caldac_cache.sv
module caldac_cache #(
   parameter int NUM_CH  = 8,
   parameter int CH_W    = 4,
   parameter int VAL_W   = 8,
   parameter int RST_VAL = 127
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_chan,
   input  logic [VAL_W-1:0] wr_val,
   input  logic [CH_W-1:0]  look_chan,
   output logic [VAL_W-1:0] look_val,
   input  logic [CH_W-1:0]  rd_chan,
   output logic [VAL_W-1:0] rd_val
);

   logic [NUM_CH-1:0][VAL_W-1:0] entry;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            entry[g] <= VAL_W'(RST_VAL);
         else if (wr_en && wr_chan == CH_W'(g))
            entry[g] <= wr_val;
      end
   end

   always_comb begin
      look_val = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (look_chan == CH_W'(i)) look_val = entry[i];
   end

   logic [VAL_W-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (rd_chan == CH_W'(i)) rd_next = entry[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_val <= '0;
      else        rd_val <= rd_next;
   end

   // R5
   cache_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> entry[$past(wr_chan)] == $past(wr_val));

endmodule

// File: rtl/caldac_shifter.sv
module caldac_shifter
   import caldac_pkg::*;
#(
   parameter int FRAME_W = 12,
   parameter int HALF    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               sclk,
   output logic               sdata,
   output logic               load,
   output logic               fin,
   output logic               active
);

   localparam int BC_W = $clog2(FRAME_W);
   localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;

   sh_state_t          st;
   logic [FRAME_W-1:0] sh;
   logic [BC_W-1:0]    bitc;
   logic               ph_done;

   if (HALF == 1) begin : g_ph_one
      assign ph_done = 1'b1;
   end else begin : g_ph_cnt
      logic [PH_W-1:0] ph;
      always_ff @(posedge clk) begin
         if (!rst_n || st == SH_IDLE || ph_done) ph <= '0;
         else                                    ph <= ph + 1'b1;
      end
      assign ph_done = (ph == PH_W'(HALF - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SH_IDLE;
         sh   <= '0;
         bitc <= '0;
         fin  <= 1'b0;
      end else begin
         fin <= (st == SH_LD) && ph_done;
         case (st)
            SH_IDLE: if (start) begin
               sh   <= frame;
               bitc <= '0;
               st   <= SH_LO;
            end
            SH_LO: if (ph_done) st <= SH_HI;
            SH_HI: if (ph_done) begin
               if (bitc == BC_W'(FRAME_W - 1)) begin
                  st <= SH_LD;
               end else begin
                  bitc <= bitc + 1'b1;
                  sh   <= sh << 1;
                  st   <= SH_LO;
               end
            end
            SH_LD: if (ph_done) st <= SH_IDLE;
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign sclk   = (st == SH_HI);
   assign load   = (st == SH_LD);
   assign sdata  = ((st == SH_LO) || (st == SH_HI)) && sh[FRAME_W-1];
   assign active = (st != SH_IDLE);

   // R3
   load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !sclk);

   // R9
   sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdata));

   // R3
   load_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load) |-> (bitc == BC_W'(FRAME_W - 1)));

endmodule

// File: rtl/caldac_loader.sv
module caldac_loader
   import caldac_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 4,
   parameter int VAL_W  = 8,
   parameter int HALF   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CH_W-1:0]  req_chan,
   input  logic [VAL_W-1:0] req_value,
   output logic             busy,
   output logic             done,
   input  logic [CH_W-1:0]  rd_chan,
   output logic [VAL_W-1:0] rd_value,
   output logic             dac_sclk,
   output logic             dac_sdata,
   output logic             dac_load,
   output logic             eep_sel,
   output logic             eep_wr_rel
);

   localparam int FRAME_W = CH_W + VAL_W;
   localparam int MID     = (1 << (VAL_W - 1)) - 1;

   if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_nch
      $error("NUM_CH must lie between 1 and 2**CH_W");
   end
   if (CH_W < 1 || VAL_W < 2 || HALF < 1) begin : g_bad_w
      $error("CH_W, VAL_W or HALF out of range");
   end

   ld_state_t          st;
   logic [CH_W-1:0]    ich;
   logic               accept, in_range, hit, launch, skip;
   logic [VAL_W-1:0]   look_val;
   logic               sh_start, sh_fin, sh_active;
   logic [FRAME_W-1:0] sh_frame;

   assign in_range = ({1'b0, req_chan} < (CH_W + 1)'(NUM_CH));
   assign accept   = (st == LD_IDLE) && req_valid && in_range;
   assign hit      = (look_val == req_value);
   assign skip     = accept && hit;
   assign launch   = accept && !hit;
   assign sh_start = (st == LD_INIT_GO) || launch;
   assign sh_frame = (st == LD_INIT_GO) ? {ich, VAL_W'(MID)}
                                        : {req_chan, req_value};

   caldac_cache #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .VAL_W  (VAL_W),
      .RST_VAL(MID)
   ) u_cache (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (launch),
      .wr_chan  (req_chan),
      .wr_val   (req_value),
      .look_chan(req_chan),
      .look_val (look_val),
      .rd_chan  (rd_chan),
      .rd_val   (rd_value)
   );

   caldac_shifter #(
      .FRAME_W(FRAME_W),
      .HALF   (HALF)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sh_start),
      .frame (sh_frame),
      .sclk  (dac_sclk),
      .sdata (dac_sdata),
      .load  (dac_load),
      .fin   (sh_fin),
      .active(sh_active)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= LD_INIT_GO;
         ich  <= '0;
         done <= 1'b0;
      end else begin
         done <= skip || ((st == LD_XFER) && sh_fin);
         case (st)
            LD_INIT_GO:   st <= LD_INIT_WAIT;
            LD_INIT_WAIT: if (sh_fin) begin
               if (ich == CH_W'(NUM_CH - 1)) begin
                  st <= LD_IDLE;
               end else begin
                  ich <= ich + 1'b1;
                  st  <= LD_INIT_GO;
               end
            end
            LD_IDLE: if (launch) st <= LD_XFER;
            LD_XFER: if (sh_fin) st <= LD_IDLE;
            default: st <= LD_IDLE;
         endcase
      end
   end

   assign busy       = (st != LD_IDLE);
   assign eep_sel    = 1'b0;
   assign eep_wr_rel = 1'b0;

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip |=> (done && !sh_active));

   // R5
   launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (busy && sh_active));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LD_XFER && !sh_fin) |=> busy);

endmodule

// File: tb/caldac_loader_tb.sv
module caldac_loader_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NCH  = 8;
   localparam int CW   = 4;
   localparam int VW   = 8;
   localparam int HALF = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [CW-1:0] req_chan = '0;
   logic [VW-1:0] req_value = '0;
   logic [CW-1:0] rd_chan = '0;
   logic          busy, done, dac_sclk, dac_sdata, dac_load, eep_sel, eep_wr_rel;
   logic [VW-1:0] rd_value;

   caldac_loader #(.NUM_CH(NCH), .CH_W(CW), .VAL_W(VW), .HALF(HALF)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_value(req_value), .busy(busy), .done(done), .rd_chan(rd_chan),
      .rd_value(rd_value), .dac_sclk(dac_sclk), .dac_sdata(dac_sdata),
      .dac_load(dac_load), .eep_sel(eep_sel), .eep_wr_rel(eep_wr_rel));

   always #2.5 clk = ~clk;

   int n_vec = 0;
   int n_err = 0;
   int model[NCH];
   int exp_q[$];
   int frames_seen = 0;
   int nbits = 0;
   int bits = 0;
   bit mon_on = 1'b0;
   bit in_init = 1'b1;
   bit pending = 1'b0;
   bit prev_busy = 1'b1;
   bit prev_sclk = 1'b0;
   bit prev_sdata = 1'b0;
   bit prev_load = 1'b0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_vec++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   endtask

   // behavioural reference, sampled 1 ns after each rising edge
   initial begin
      for (int i = 0; i < NCH; i++) begin
         model[i] = 127;
         exp_q.push_back((i << 8) | 127);   // R1 sweep order
      end
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            bit acc, hit;
            int c, v, rc, exp_rd;
            c = int'(req_chan);
            v = int'(req_value);
            rc = int'(rd_chan);
            // R8 readback before any update of this edge
            exp_rd = (rc < NCH) ? model[rc] : 0;
            chk(int'(rd_value) == exp_rd, "R8 readback", int'(rd_value), exp_rd);
            // R4
            chk(!eep_sel && !eep_wr_rel, "R4 memory selects low",
                {eep_sel, eep_wr_rel}, 0);
            acc = req_valid && !prev_busy && (c < NCH);   // R7 filter
            hit = acc && (model[c] == v);
            if (acc && !hit) begin
               model[c] = v;
               exp_q.push_back((c << 8) | v);
               pending = 1'b1;
               chk(busy, "R5 busy after accept", busy, 1);
            end
            if (hit) begin
               chk(done && !busy, "R6 skip completes next cycle", {done, busy}, 2);
            end else if (done) begin
               chk(pending, "R7 done without accepted request", done, 0);
               chk(exp_q.size() == 0, "R5 frame sent before done", exp_q.size(), 0);
               pending = 1'b0;
            end
            // R10
            chk(!(done && busy), "R10 done while busy", {done, busy}, 2);
            if (in_init) begin
               chk(!done, "R1 no done during sweep", done, 0);
               if (!busy) begin
                  in_init = 1'b0;
                  chk(frames_seen == NCH, "R1 sweep frame count", frames_seen, NCH);
               end
            end
            if (prev_busy && !busy && pending)
               chk(done, "R5 done when busy falls", done, 1);
            // R9 data hold while clock high
            if (dac_sclk && prev_sclk)
               chk(dac_sdata == prev_sdata, "R9 data stable", dac_sdata, prev_sdata);
            // R3 exclusion
            chk(!(dac_load && dac_sclk), "R3 load with clock high",
                {dac_load, dac_sclk}, 2);
            // R2 decode
            if (dac_sclk && !prev_sclk) begin
               bits = (bits << 1) | int'(dac_sdata);
               nbits++;
            end
            if (dac_load && !prev_load) begin
               int got;
               got = bits & 12'hfff;
               chk(nbits == 12, "R3 load after 12 bits", nbits, 12);
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R7 unexpected frame", got, 0);
               end else begin
                  int e;
                  e = exp_q.pop_front();
                  chk(got == e, "R2 frame content", got, e);
               end
               frames_seen++;
               nbits = 0;
               bits = 0;
            end
            prev_busy = busy;
            prev_sclk = dac_sclk;
            prev_sdata = dac_sdata;
            prev_load = dac_load;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   task automatic send(input int c, input int v);
      @(negedge clk);
      req_valid = 1'b1;
      req_chan  = CW'(c);
      req_value = VW'(v);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(busy && !done, "R1 busy in reset", {busy, done}, 2);
      chk(!dac_sclk && !dac_load, "R9 clock idle low in reset",
          {dac_sclk, dac_load}, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      wait_idle();
      chk(frames_seen == NCH, "R1 sweep complete", frames_seen, NCH);

      // R5 a real transfer, then R7 requests during busy
      send(3, 'hA5);
      send(3, 'h00);
      send(5, 'h11);
      wait_idle();
      repeat (2) @(negedge clk);

      // R6 matching value
      send(3, 'hA5);
      repeat (2) @(negedge clk);

      // R6 back-to-back skips, then R7 out-of-range channel
      @(negedge clk); req_valid = 1'b1; req_chan = 0; req_value = 127;
      @(negedge clk); req_chan = 1;
      @(negedge clk); req_chan = 12; req_value = 'h55;
      @(negedge clk); req_valid = 1'b0;
      repeat (2) @(negedge clk);

      // R2 edge patterns
      send(NCH - 1, 'h00);
      wait_idle();

      // R8 read and write of the same channel coincide
      rd_chan = 0;
      send(0, 'hFF);
      wait_idle();
      send(0, 'h7F);
      wait_idle();

      // R8 sweep including out-of-range addresses
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         rd_chan = CW'(c);
      end
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all frames delivered", exp_q.size(), 0);
      chk(!pending, "R5 no transfer left open", pending, 0);
      chk(frames_seen == NCH + 4, "R5 frame total", frames_seen, NCH + 4);
      finish_run();
   end

endmodule